// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast local-oscillator clock by a programmable 15-bit ratio. It is the feedback divider of a frequency synthesizer. Inside, a prescaler that can count 16 or 17 input clocks is followed by a 4-bit swallow counter and an 11-bit main counter. The ratio word is split into a main count M (upper 11 bits) and a swallow count A (lower 4 bits). During each division cycle the prescaler runs A times at 17 and M-A times at 16, so one cycle lasts 16*M + A input clocks.

Software-facing logic writes a new ratio word together with a one-clock load strobe. The word is held as pending and is adopted only where one division cycle meets the next, so a cycle that is already running keeps its length. The block produces a one-clock pulse at the end of every division cycle. It also produces a square wave at half the pulse rate, which can be routed to a test pin. A word below the legal minimum of 240 raises an error flag. Such a word is still applied, but its cycle length is not guaranteed.

Top module: `fdiv_top`

## Requirements
- R1: While reset is asserted and right after it, div_pulse and div_half are 0 and ratio_err is 0. The divider starts with a ratio of 240, so the spacing between its first pulses is 240 clocks.
- R2: With ratio word W, M = W[14:4] and A = W[3:0]. For every legal W (240 to 32767), consecutive div_pulse rising events are exactly 16*M + A clk_lo cycles apart, including A = 0 and A = 15.
- R3: div_pulse is high for exactly one clk_lo cycle per division cycle.
- R4: A word loaded during a division cycle does not change the length of that cycle. It sets the length of the next cycle.
- R5: When several words are loaded within one division cycle, only the last one is used for the next cycle.
- R6: div_half changes level on the same edge at which div_pulse rises and holds its level at every other edge.
- R7: One clock after a load strobe, ratio_err is 1 if the loaded word is below 240 and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lo | input | 1 | Local-oscillator clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ratio_load | input | 1 | One-clock strobe that captures ratio_word |
| ratio_word | input | 15 | Division ratio: main count in bits 14:4, swallow count in bits 3:0 |
| div_pulse | output | 1 | One-clock pulse at the end of each division cycle |
| div_half | output | 1 | Toggles on each div_pulse (divider output divided by two) |
| ratio_err | output | 1 | Set when the last loaded word was below 240 |

## Verification
The bench drives ratios with A = 0 and A = 15, at both ends of the legal range. If the swallow phase were wrong, these cycles would come out 16 clocks short or A clocks long. Each new word is loaded just after a pulse, and the bench then checks two spacings: the running cycle must keep its old length, and only the cycle after it may take the new one. A design that reloads at once would cut the running cycle short. Loading two words in a row checks that the later word wins. Loading an illegal word and then a legal one checks that the error flag both sets and clears.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int unsigned A_W       = 4;
  localparam int unsigned M_W       = 11;
  localparam int unsigned RATIO_W   = A_W + M_W;
  localparam int unsigned MIN_RATIO = 240;
  localparam int unsigned DEF_RATIO = 240;
endpackage

// File: rtl/fdiv_rst_sync.sv
module fdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fdiv_prescaler.sv
module fdiv_prescaler #(
  parameter int unsigned A_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mod_hi,
  output logic pre_tc
);
  localparam int unsigned CNT_W = A_W + 1;
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'((1 << A_W) - 1);
  localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(1 << A_W);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last;

  always_comb begin
    last   = mod_hi ? LAST_HI : LAST_LO;
    pre_tc = (cnt_q == last);
    cnt_d  = pre_tc ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fdiv_cycle_ctr.sv
module fdiv_cycle_ctr #(
  parameter int unsigned A_W = 4,
  parameter int unsigned M_W = 11,
  parameter logic [A_W-1:0] A_RST = '0,
  parameter logic [M_W-1:0] M_RST = M_W'(15)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pre_tc,
  input  logic [M_W-1:0] m_next,
  input  logic [A_W-1:0] a_next,
  output logic           mod_hi,
  output logic           cyc_end
);
  logic [M_W-1:0] m_q, m_d;
  logic [A_W-1:0] a_q, a_d;
  logic           m_last;

  always_comb begin
    m_last  = (m_q <= M_W'(1));
    cyc_end = pre_tc && m_last;
    mod_hi  = (a_q != '0);
    if (m_last) begin
      m_d = m_next;
      a_d = a_next;
    end else begin
      m_d = m_q - 1'b1;
      a_d = mod_hi ? a_q - 1'b1 : a_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= M_RST;
      a_q <= A_RST;
    end else if (pre_tc) begin
      m_q <= m_d;
      a_q <= a_d;
    end
  end
endmodule

// File: rtl/fdiv_ratio_reg.sv
module fdiv_ratio_reg #(
  parameter int unsigned RATIO_W   = 15,
  parameter int unsigned MIN_RATIO = 240,
  parameter int unsigned DEF_RATIO = 240
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [RATIO_W-1:0] word,
  input  logic               cyc_end,
  output logic [RATIO_W-1:0] next_ratio,
  output logic [RATIO_W-1:0] act_ratio,
  output logic               err
);
  logic [RATIO_W-1:0] pend_q, act_q;
  logic               pend_v_q, pend_v_d;
  logic               err_q, err_d;

  always_comb begin
    if (load)          next_ratio = word;
    else if (pend_v_q) next_ratio = pend_q;
    else               next_ratio = act_q;
    pend_v_d = cyc_end ? 1'b0 : (pend_v_q || load);
    err_d    = (word < RATIO_W'(MIN_RATIO));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= RATIO_W'(DEF_RATIO);
      act_q    <= RATIO_W'(DEF_RATIO);
      pend_v_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      pend_v_q <= pend_v_d;
      if (load)    pend_q <= word;
      if (cyc_end) act_q  <= next_ratio;
      if (load)    err_q  <= err_d;
    end
  end

  assign act_ratio = act_q;
  assign err       = err_q;
endmodule

// File: rtl/fdiv_top.sv
module fdiv_top
  import fdiv_pkg::*;
#(
  parameter int unsigned DIV_A_W     = A_W,
  parameter int unsigned DIV_M_W     = M_W,
  parameter int unsigned DIV_MIN     = MIN_RATIO,
  parameter int unsigned DIV_DEFAULT = DEF_RATIO
) (
  input  logic                       clk_lo,
  input  logic                       rst_n,
  input  logic                       ratio_load,
  input  logic [DIV_A_W+DIV_M_W-1:0] ratio_word,
  output logic                       div_pulse,
  output logic                       div_half,
  output logic                       ratio_err
);
  localparam int unsigned W = DIV_A_W + DIV_M_W;
  localparam logic [W-1:0] DEF_W = W'(DIV_DEFAULT);

  logic           rst_sync_n;
  logic           pre_tc;
  logic           mod_hi;
  logic           cyc_end;
  logic [W-1:0]   next_ratio;
  logic [W-1:0]   act_ratio;
  logic           pulse_q, pulse_d;
  logic           half_q, half_d;

  fdiv_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk_lo),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fdiv_prescaler #(.A_W(DIV_A_W)) u_pre (
    .clk    (clk_lo),
    .rst_n  (rst_sync_n),
    .mod_hi (mod_hi),
    .pre_tc (pre_tc)
  );

  fdiv_cycle_ctr #(
    .A_W   (DIV_A_W),
    .M_W   (DIV_M_W),
    .A_RST (DEF_W[DIV_A_W-1:0]),
    .M_RST (DEF_W[W-1:DIV_A_W])
  ) u_cyc (
    .clk     (clk_lo),
    .rst_n   (rst_sync_n),
    .pre_tc  (pre_tc),
    .m_next  (next_ratio[W-1:DIV_A_W]),
    .a_next  (next_ratio[DIV_A_W-1:0]),
    .mod_hi  (mod_hi),
    .cyc_end (cyc_end)
  );

  fdiv_ratio_reg #(
    .RATIO_W   (W),
    .MIN_RATIO (DIV_MIN),
    .DEF_RATIO (DIV_DEFAULT)
  ) u_ratio (
    .clk        (clk_lo),
    .rst_n      (rst_sync_n),
    .load       (ratio_load),
    .word       (ratio_word),
    .cyc_end    (cyc_end),
    .next_ratio (next_ratio),
    .act_ratio  (act_ratio),
    .err        (ratio_err)
  );

  always_comb begin
    pulse_d = cyc_end;
    half_d  = half_q ^ cyc_end;
  end

  always_ff @(posedge clk_lo or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pulse_q <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
      half_q  <= half_d;
    end
  end

  assign div_pulse = pulse_q;
  assign div_half  = half_q;
endmodule

// File: rtl/fdiv_chk.sv
module fdiv_chk #(
  parameter int unsigned W       = 15,
  parameter int unsigned MIN_VAL = 240
) (
  input logic         clk,
  input logic         rst_n,
  input logic         div_pulse,
  input logic         div_half,
  input logic         ratio_load,
  input logic [W-1:0] ratio_word,
  input logic         ratio_err,
  input logic         cyc_end,
  input logic         mod_hi,
  input logic [W-1:0] act_ratio
);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  a_r6_half_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_pulse) |-> (div_half != $past(div_half)));

  a_r6_half_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !div_pulse |-> $stable(div_half));

  a_r7_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_load && (ratio_word < W'(MIN_VAL))) |=> ratio_err);

  a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_load && (ratio_word >= W'(MIN_VAL))) |=> !ratio_err);

  a_r4_ratio_fixed_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end |=> $stable(act_ratio));

  a_r2_swallow_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_hi && !cyc_end) |=> !mod_hi);

  a_r3_pulse_follows_end: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> div_pulse);
endmodule

bind fdiv_top fdiv_chk #(.W(DIV_A_W + DIV_M_W), .MIN_VAL(DIV_MIN)) u_chk (
  .clk        (clk_lo),
  .rst_n      (rst_sync_n),
  .div_pulse  (div_pulse),
  .div_half   (div_half),
  .ratio_load (ratio_load),
  .ratio_word (ratio_word),
  .ratio_err  (ratio_err),
  .cyc_end    (cyc_end),
  .mod_hi     (mod_hi),
  .act_ratio  (act_ratio)
);

// File: tb/tb_fdiv_top.sv
module tb_fdiv_top;
  localparam int NV = 9;
  localparam logic [14:0] VEC [0:NV-1] = '{
    15'd255, 15'd256, 15'd271, 15'd1000, 15'd4096,
    15'd32767, 15'd5007, 15'd240, 15'd300
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ratio_load;
  logic [14:0] ratio_word;
  logic        div_pulse, div_half, ratio_err;

  int checks = 0;
  int errors = 0;
  logic exp_half = 1'b0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  fdiv_top dut (
    .clk_lo     (clk),
    .rst_n      (rst_n),
    .ratio_load (ratio_load),
    .ratio_word (ratio_word),
    .div_pulse  (div_pulse),
    .div_half   (div_half),
    .ratio_err  (ratio_err)
  );

  function automatic int expect_len(input logic [14:0] w);
    return 16 * int'(w[14:4]) + int'(w[3:0]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sync to a pulse; returns at the negedge where div_pulse is seen high.
  task automatic wait_pulse();
    do @(negedge clk); while (!div_pulse);
    exp_half = ~exp_half;
    chk("R6 half level", int'(div_half), int'(exp_half));
  endtask

  // Count clocks from the current pulse to the next one.
  task automatic measure(output int len);
    len = 0;
    do begin
      @(negedge clk);
      len++;
      if (!div_pulse) chk("R6 half hold", int'(div_half), int'(exp_half));
    end while (!div_pulse);
    exp_half = ~exp_half;
    chk("R6 half level", int'(div_half), int'(exp_half));
  endtask

  task automatic load_word(input logic [14:0] w);
    ratio_load = 1'b1;
    ratio_word = w;
    @(negedge clk);
    ratio_load = 1'b0;
    chk("R7 err flag", int'(ratio_err), int'(w < 15'd240));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int len;
    logic [14:0] prev;
    logic [14:0] rw;
    rst_n = 1'b0;
    ratio_load = 1'b0;
    ratio_word = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 pulse in reset", int'(div_pulse), 0);
    chk("R1 half in reset", int'(div_half), 0);
    chk("R1 err in reset", int'(ratio_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pulse after reset", int'(div_pulse), 0);
    chk("R1 err after reset", int'(ratio_err), 0);
    wait_pulse();
    measure(len);
    chk("R1 default spacing 240", len, 240);
    measure(len);
    chk("R3 one pulse per 240", len, 240);

    // Table walk: R2 spacing, R4 boundary-only update
    prev = 15'd240;
    for (int i = 0; i < NV; i++) begin
      load_word(VEC[i]);
      measure(len);
      chk("R4 running cycle keeps old ratio", len + 1, expect_len(prev));
      measure(len);
      chk("R2 spacing 16*M+A", len, expect_len(VEC[i]));
      prev = VEC[i];
    end

    // Random legal ratios, swallow count forced to 0 and 15 alternately
    for (int k = 0; k < 4; k++) begin
      rw = 15'($urandom_range(240, 3000));
      rw[3:0] = (k % 2 == 0) ? 4'd0 : 4'd15;
      if (rw < 15'd240) rw = 15'd255;
      load_word(rw);
      measure(len);
      chk("R4 old length", len + 1, expect_len(prev));
      measure(len);
      chk("R2 random A0/A15 spacing", len, expect_len(rw));
      prev = rw;
    end

    // R5: two loads in one cycle, last wins
    load_word(15'd500);
    load_word(15'd700);
    measure(len);
    chk("R5 old length kept", len + 2, expect_len(prev));
    measure(len);
    chk("R5 last word wins", len, 700);
    prev = 15'd700;

    // R7: illegal word raises err, legal clears it
    load_word(15'd100);
    chk("R7 err set", int'(ratio_err), 1);
    measure(len);
    chk("R4 old length before illegal", len + 1, expect_len(prev));
    load_word(15'd271);
    chk("R7 err cleared", int'(ratio_err), 0);
    measure(len);
    measure(len);
    chk("R2 recovered 271", len, 271);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule